// File: doc/BRIEF.md
# External Interrupt Sense Unit

This block watches one port pin and raises an interrupt request when the pin shows the condition that software picked. A two-bit sense field selects the condition: the pin held low, a high-to-low transition, or a low-to-high transition. The fourth code is reserved and never fires. In the two edge modes a detected transition is latched into a flag bit. The flag holds until software writes a one to it or the processor acknowledges the interrupt. In the level mode the flag bit simply mirrors the pin: it reads as one while the pin is low, and nothing is latched.

The request goes out only when three things are true at once: the flag is visible, its mask bit is set, and the global enable bit is set. A separate block input holds the request low, for example while the processor is in a critical section. Flags are still captured while it is high. Whenever the request is high, the vector output carries a fixed, parameterised vector value. Software reaches the four small registers through a simple write strobe and address, and reads them back through a combinational read port.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset the sense field, mask bit, latched flag and global enable are all zero; `irq_req` is low and `irq_vec` is zero. With the pin held high, every register reads 0x00.
- R2: With sense code 00, the flag bit reads 1 and the request (when enabled) is high in the same cycle that pin 0 is low. Both drop as soon as the pin is high again. Nothing is latched.
- R3: With sense code 10, a change of pin 0 from 1 to 0 between two consecutive clock samples sets the flag. The flag is visible after the clock edge that samples the new low level.
- R4: With sense code 11, a change of pin 0 from 0 to 1 between two consecutive samples sets the flag in the same way.
- R5: In either edge mode, a pin that holds its level does not set the flag again after it has been cleared.
- R6: Sense code 01 is reserved and never sets the flag or raises a request.
- R7: `irq_req` equals flag AND mask bit AND global enable AND NOT `irq_block`. `irq_vec` equals the parameter `IRQ_VEC` while `irq_req` is high and zero otherwise.
- R8: While `irq_block` is high, `irq_req` stays low, but edge events are still latched. The request appears once the block input falls.
- R9: A write with bit 6 set to the flag register clears the latched flag. A write with bit 6 clear has no effect. A one-cycle pulse on `irq_ack` also clears it.
- R10: Register map, selected by `reg_addr`: 0 is the sense field in bits [1:0]; 1 is the mask in bit 6; 2 is the flag in bit 6; 3 is the global enable in bit 7. All other bits read as 0.
- R11: Only bit 0 of `pin_in` is sensed. Activity on bits 7..1 never sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| pin_in | input | 8 | Port pins; only bit 0 is sensed |
| irq_block | input | 1 | Holds the request low while high |
| irq_ack | input | 1 | Acknowledge pulse; clears the latched flag |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 22 | Vector while the request is high |

## Verification
The bench uses the default build: an 8-bit port, 8-bit registers, a 22-bit vector and the default vector value. With this small configuration every sense code can be crossed with all four pairs of (previous pin, new pin). The bench checks each outcome against a sense function it writes out itself. It also sweeps all eight combinations of mask, global enable and block input against a latched flag. Clear-by-write, acknowledge, held levels and activity on the unsensed pins are exercised one at a time.

// File: rtl/eis_pkg.sv
package eis_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_RSVD = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_mode_e;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_MASK = 2'd1,
    REG_FLAG = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;

  // Edge modes have the upper code bit set.
  function automatic logic is_edge_mode(sense_mode_e m);
    return m[1];
  endfunction

  // Event condition for one clock, given the previous and current pin sample.
  function automatic logic sense_hit(sense_mode_e m, logic primed,
                                     logic prev, logic now);
    case (m)
      SENSE_LOW:  return ~now;
      SENSE_FALL: return primed & prev & ~now;
      SENSE_RISE: return primed & ~prev & now;
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/eis_pin_sampler.sv
module eis_pin_sampler
  import eis_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pin_i,
  input  sense_mode_e mode_i,
  output logic        prev_o,
  output logic        primed_o,
  output logic        event_o
);

  logic prev_q, primed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= pin_i;
      primed_q <= 1'b1;
    end
  end

  assign prev_o   = prev_q;
  assign primed_o = primed_q;
  assign event_o  = sense_hit(mode_i, primed_q, prev_q, pin_i);

  // R6
  rsvd_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == SENSE_RSVD) |-> !event_o);

  // R5
  held_level_no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_edge_mode(mode_i) && pin_i == $past(pin_i)) |-> !event_o);

endmodule

// File: rtl/eis_flag_latch.sv
module eis_flag_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;

  // Set takes priority over a clear in the same cycle, so no event is lost.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R3
  set_captured_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);

  // R9
  clear_effective_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);

endmodule

// File: rtl/eis_regs.sv
module eis_regs
  import eis_pkg::*;
#(
  parameter int REG_W    = 8,
  parameter int MASK_BIT = 6,
  parameter int FLAG_BIT = 6,
  parameter int GIE_BIT  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  reg_sel_e         addr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             flag_view_i,
  output logic [REG_W-1:0] rdata_o,
  output sense_mode_e      mode_o,
  output logic             mask_o,
  output logic             gie_o,
  output logic             flag_clr_o
);

  sense_mode_e mode_q;
  logic        mask_q, gie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SENSE_LOW;
      mask_q <= 1'b0;
      gie_q  <= 1'b0;
    end else if (wr_i) begin
      case (addr_i)
        REG_CTRL: mode_q <= sense_mode_e'(wdata_i[1:0]);
        REG_MASK: mask_q <= wdata_i[MASK_BIT];
        REG_STAT: gie_q  <= wdata_i[GIE_BIT];
        default:  ;
      endcase
    end
  end

  assign flag_clr_o = wr_i && addr_i == REG_FLAG && wdata_i[FLAG_BIT];

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_CTRL: rdata_o[1:0]    = mode_q;
      REG_MASK: rdata_o[MASK_BIT] = mask_q;
      REG_FLAG: rdata_o[FLAG_BIT] = flag_view_i;
      REG_STAT: rdata_o[GIE_BIT]  = gie_q;
      default:  rdata_o = '0;
    endcase
  end

  assign mode_o = mode_q;
  assign mask_o = mask_q;
  assign gie_o  = gie_q;

  // R10
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == REG_MASK) |=> mask_o == $past(wdata_i[MASK_BIT]));

  // R10
  gie_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == REG_STAT) |=> gie_o == $past(wdata_i[GIE_BIT]));

endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import eis_pkg::*;
#(
  parameter int                 PORT_W   = 8,
  parameter int                 REG_W    = 8,
  parameter int                 VEC_W    = 22,
  parameter logic [VEC_W-1:0]   IRQ_VEC  = 22'h000001,
  parameter int                 MASK_BIT = 6,
  parameter int                 FLAG_BIT = 6,
  parameter int                 GIE_BIT  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [PORT_W-1:0] pin_in,
  input  logic              irq_block,
  input  logic              irq_ack,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec
);

  localparam int SENSE_PIN = 0;

  sense_mode_e mode;
  logic mask, gie, flag_clr_wr;
  logic pin_prev, primed, sense_event;
  logic edge_set, flag_latched, flag_view;
  logic unused_pins;

  assign unused_pins = ^pin_in[PORT_W-1:SENSE_PIN+1];

  eis_regs #(
    .REG_W(REG_W), .MASK_BIT(MASK_BIT), .FLAG_BIT(FLAG_BIT), .GIE_BIT(GIE_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_sel_e'(reg_addr)),
    .wdata_i(reg_wdata), .flag_view_i(flag_view), .rdata_o(reg_rdata),
    .mode_o(mode), .mask_o(mask), .gie_o(gie), .flag_clr_o(flag_clr_wr)
  );

  eis_pin_sampler u_sampler (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_in[SENSE_PIN]), .mode_i(mode),
    .prev_o(pin_prev), .primed_o(primed), .event_o(sense_event)
  );

  assign edge_set = sense_event && is_edge_mode(mode);

  eis_flag_latch u_flag (
    .clk(clk), .rst_n(rst_n), .set_i(edge_set),
    .clr_i(flag_clr_wr | irq_ack), .flag_o(flag_latched)
  );

  // Level mode shows the live pin; edge modes show the latch.
  always_comb begin
    case (mode)
      SENSE_LOW:  flag_view = ~pin_in[SENSE_PIN];
      SENSE_RSVD: flag_view = 1'b0;
      default:    flag_view = flag_latched;
    endcase
  end

  assign irq_req = flag_view & mask & gie & ~irq_block;
  assign irq_vec = irq_req ? IRQ_VEC : '0;

  // R8
  block_holds_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_block |-> !irq_req);

  // R7
  req_needs_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (mask && gie && flag_view));

  // R7
  vec_matches_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == (irq_vec == IRQ_VEC));

  // R2
  level_unlatched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SENSE_LOW && pin_in[SENSE_PIN]) |-> !flag_view);

  // R6
  rsvd_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SENSE_RSVD) |-> !irq_req);

endmodule

// File: tb/ext_irq_sense_tb.sv
module ext_irq_sense_tb;

  localparam logic [21:0] VEC = 22'h000001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic [7:0]  pin_in = 8'hFF;
  logic        irq_block = 1'b0;
  logic        irq_ack = 1'b0;
  logic        irq_req;
  logic [21:0] irq_vec;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  ext_irq_sense u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .irq_block(irq_block), .irq_ack(irq_ack), .irq_req(irq_req),
    .irq_vec(irq_vec)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // Independent restatement of the sense rules.
  function automatic logic expect_flag(int m, logic p, logic n);
    if (m == 0) return !n;
    if (m == 2) return p && !n;
    if (m == 3) return !p && n;
    return 1'b0;
  endfunction

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic       ef;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1: reset values
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      check($sformatf("R1 reg%0d", a), d, 8'h00);
    end
    check("R1 req", irq_req, 1'b0);
    check("R1 vec", irq_vec, 22'h0);

    // R10: register map read-back
    wr(2'd0, 8'hFF); wr(2'd1, 8'hFF); wr(2'd3, 8'hFF);
    rd(2'd0, d); check("R10 ctrl", d, 8'h03);
    rd(2'd1, d); check("R10 mask", d, 8'h40);
    rd(2'd3, d); check("R10 stat", d, 8'h80);

    // Sweep: every sense code crossed with every (prev, now) pin pair
    for (int m = 0; m < 4; m++) begin
      for (int pn = 0; pn < 4; pn++) begin
        logic p, n;
        p = pn[1]; n = pn[0];
        wr(2'd0, 8'(m));
        pin_in[0] = p;
        step(); step();
        wr(2'd2, 8'h40);
        pin_in[0] = n;
        step();
        rd(2'd2, d);
        ef = expect_flag(m, p, n);
        // R2 R3 R4 R6
        check($sformatf("R2/R3/R4/R6 flag m%0d p%0d n%0d", m, p, n), d, {1'b0, ef, 6'b0});
        // R7
        check($sformatf("R7 req m%0d p%0d n%0d", m, p, n), irq_req, ef);
        check($sformatf("R7 vec m%0d p%0d n%0d", m, p, n), irq_vec, ef ? VEC : 22'h0);
      end
    end

    // R2: level mode follows the pin without latching
    wr(2'd0, 8'h00);
    pin_in[0] = 1'b0; #1;
    check("R2 low req", irq_req, 1'b1);
    pin_in[0] = 1'b1; #1;
    check("R2 release req", irq_req, 1'b0);
    step();
    rd(2'd2, d); check("R2 not latched", d, 8'h00);

    // R7 R8: enable gating with a latched falling-edge flag
    wr(2'd0, 8'h02);
    pin_in[0] = 1'b1; step();
    irq_block = 1'b1;
    pin_in[0] = 1'b0; step();
    rd(2'd2, d); check("R8 flag captured while blocked", d, 8'h40);
    for (int c = 0; c < 8; c++) begin
      wr(2'd1, c[0] ? 8'h40 : 8'h00);
      wr(2'd3, c[1] ? 8'h80 : 8'h00);
      irq_block = c[2];
      #1;
      check($sformatf("R7/R8 gate mask%0d gie%0d blk%0d", c[0], c[1], c[2]),
            irq_req, c[0] && c[1] && !c[2]);
    end
    irq_block = 1'b0;

    // R9: writing zero to the flag bit has no effect, writing one clears
    wr(2'd2, 8'hBF);
    rd(2'd2, d); check("R9 write0 keeps", d, 8'h40);
    wr(2'd2, 8'h40);
    rd(2'd2, d); check("R9 write1 clears", d, 8'h00);
    // R9: acknowledge clears
    pin_in[0] = 1'b1; step();
    pin_in[0] = 1'b0; step();
    rd(2'd2, d); check("R9 re-set", d, 8'h40);
    irq_ack = 1'b1; step(); irq_ack = 1'b0;
    rd(2'd2, d); check("R9 ack clears", d, 8'h00);

    // R5: held high in rising mode after a cleared event
    wr(2'd0, 8'h03);
    pin_in[0] = 1'b0; step();
    pin_in[0] = 1'b1; step();
    wr(2'd2, 8'h40);
    repeat (5) step();
    rd(2'd2, d); check("R5 held level no retrigger", d, 8'h00);

    // R11: only pin 0 is sensed
    wr(2'd0, 8'h02);
    pin_in = 8'hFF; step();
    wr(2'd2, 8'h40);
    for (int k = 0; k < 6; k++) begin
      pin_in[7:1] = (k % 2 == 0) ? 7'h00 : 7'h7F;
      step();
    end
    rd(2'd2, d); check("R11 other pins ignored", d, 8'h00);
    check("R11 req low", irq_req, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule